// File: doc/BRIEF.md
# Masked Byte Substitution Pipeline

This block performs the AES byte substitution on a byte that arrives split into two shares: a masked value and the mask that was XORed into it. The caller also supplies a 4-bit and a 2-bit auxiliary mask for the subfield arithmetic, and an 8-bit fresh random value. The block returns the substituted byte as a new pair of shares. The unmasked input byte never appears on a wire, with one exception: the 4-bit field element that enters the small inverter.

Inside, the byte is mapped into a tower field (GF(2^8) over GF(2^4) over GF(2^2)). Every multiplication and XOR chain works on shares. The one nonlinear GF(2^4) inversion runs unmasked in a hiding-style unit. That unit emits a constant-weight 2-of-7 code word. Two register stages split the logic into three stages. A phase bit toggles on every clock edge, and each stage drives zeros while it is in its precharge phase. The terms that both the first and third stages use are held in one register group. That group is loaded once per operation. A new byte is taken every second cycle.

Top module: `masked_sbox_top`

## Requirements
- R1: For every input byte x and every mask, data_o XOR mask_o in the result cycle equals the AES S-box of x, where x = data_i XOR mask_i at acceptance.
- R2: mask_o depends only on rnd_i and is XOR-linear in it: mask(a) XOR mask(b) = mask(a XOR b), and rnd_i = 0 gives mask_o = 0.
- R3: ready_o is low in the first cycle after reset is released and then toggles on every rising edge.
- R4: An input is accepted at a rising edge when in_valid_i and ready_o are both high. valid_o is then high for exactly one cycle, the cycle that begins at the second rising edge after acceptance.
- R5: in_valid_i raised while ready_o is low is ignored and produces no valid_o.
- R6: data_o and mask_o are zero in every cycle in which valid_o is low.
- R7: q_i and r_i have no effect on data_o or mask_o.
- R8: Inputs may be presented in every ready cycle. Results then come out one per two cycles, in input order.
- R9: An unmasked input of 0x00, which has no field inverse, yields 0x63.
- R10: While reset is held and in the first cycle after it, valid_o is low and data_o and mask_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte offered |
| ready_o | output | 1 | Evaluate phase of the first stage; input taken when both are high |
| data_i | input | 8 | Masked input byte |
| mask_i | input | 8 | Mask share of the input byte |
| q_i | input | 4 | Auxiliary 4-bit mask for the pre-inversion sum |
| r_i | input | 2 | Auxiliary 2-bit mask refreshing the low GF(2^2) half of q_i |
| rnd_i | input | 8 | Fresh random value that becomes the output mask |
| valid_o | output | 1 | Result shares present |
| data_o | output | 8 | Masked substituted byte |
| mask_o | output | 8 | Mask share of the substituted byte |

## Verification
The field sizes are fixed by the package, so the bench builds the block with its defaults. Those defaults are small enough that the bench sweeps all 256 unmasked byte values four times. The first pass uses zero masks and the others use pseudo-random masks and auxiliary masks, so every inverter entry is reached, including the zero element, along with many mask combinations on each. The bench also directly tests the linearity of the output mask in rnd_i, the independence of the result from q_i and r_i, and the phase and latency rules.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int SUB_W  = NIB_W / 2;
  localparam int CODE_W = NIB_W + 3;  // word, flag, two fill bits
  localparam logic [BYTE_W-1:0] AFF_C = 8'h63;
  localparam logic [SUB_W-1:0]  N_GF4 = 2'b10;   // z^2 + z + w
  localparam logic [NIB_W-1:0]  NU    = 4'b1000; // y^2 + y + w*z

  function automatic logic [SUB_W-1:0] mul4(logic [SUB_W-1:0] a, logic [SUB_W-1:0] b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  function automatic logic [SUB_W-1:0] sq4(logic [SUB_W-1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  function automatic logic [NIB_W-1:0] mul16(logic [NIB_W-1:0] a, logic [NIB_W-1:0] b);
    logic [SUB_W-1:0] hh;
    hh = mul4(a[3:2], b[3:2]);
    return {hh ^ mul4(a[3:2], b[1:0]) ^ mul4(a[1:0], b[3:2]),
            mul4(hh, N_GF4) ^ mul4(a[1:0], b[1:0])};
  endfunction

  function automatic logic [NIB_W-1:0] sq16(logic [NIB_W-1:0] a);
    return mul16(a, a);
  endfunction

  function automatic logic [NIB_W-1:0] inv16(logic [NIB_W-1:0] a);
    logic [SUB_W-1:0] d, di;
    d  = mul4(sq4(a[3:2]), N_GF4) ^ mul4(a[3:2], a[1:0]) ^ sq4(a[1:0]);
    di = sq4(d);
    return {mul4(a[3:2], di), mul4(a[3:2] ^ a[1:0], di)};
  endfunction

  function automatic logic [BYTE_W-1:0] lin_map(logic [BYTE_W*BYTE_W-1:0] m, logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int k = 0; k < BYTE_W; k++) if (v[k]) r ^= m[k*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] affine_lin(logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    r = b;
    for (int n = 1; n <= 4; n++) r ^= (b << n) | (b >> (BYTE_W - n));
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] aes_mul(logic [BYTE_W-1:0] a, logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [BYTE_W-1:0] find_root(logic [BYTE_W-1:0] c);
    logic [BYTE_W-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int v = 2; v < 256; v++)
      if (!found && ((aes_mul(8'(v), 8'(v)) ^ 8'(v)) == c)) begin
        r = 8'(v);
        found = 1'b1;
      end
    return r;
  endfunction

  // tower element bit k -> image of basis product in the AES field
  function automatic logic [BYTE_W*BYTE_W-1:0] build_t2a();
    logic [BYTE_W-1:0] aw, az, ay, awz;
    aw  = find_root(8'h01);
    az  = find_root(aw);
    awz = aes_mul(aw, az);
    ay  = find_root(awz);
    return {aes_mul(awz, ay), aes_mul(az, ay), aes_mul(aw, ay), ay,
            awz, az, aw, 8'h01};
  endfunction

  function automatic logic [BYTE_W*BYTE_W-1:0] build_a2t(logic [BYTE_W*BYTE_W-1:0] fwd);
    logic [BYTE_W*BYTE_W-1:0] m;
    m = '0;
    for (int i = 0; i < BYTE_W; i++)
      for (int t = 0; t < 256; t++)
        if (lin_map(fwd, 8'(t)) == (8'h01 << i)) m[i*BYTE_W +: BYTE_W] = 8'(t);
    return m;
  endfunction

  localparam logic [BYTE_W*BYTE_W-1:0] T2A = build_t2a();
  localparam logic [BYTE_W*BYTE_W-1:0] A2T = build_a2t(T2A);
endpackage

// File: rtl/sbox_stage1.sv
module sbox_stage1
  import sbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic [NIB_W-1:0]  q_i,
  input  logic [SUB_W-1:0]  r_i,
  output logic [NIB_W-1:0]  h1_o,
  output logic [NIB_W-1:0]  h2_o,
  output logic [NIB_W-1:0]  ahm_o,
  output logic [NIB_W-1:0]  alm_o,
  output logic [NIB_W-1:0]  am10_o,
  output logic [NIB_W-1:0]  am01_o,
  output logic [NIB_W-1:0]  m01_o,
  output logic [BYTE_W-1:0] mt_o
);
  logic [BYTE_W-1:0] at, mt;
  logic [NIB_W-1:0]  qq, am10, am01, m01, h1, h2;

  always_comb begin
    at   = lin_map(A2T, data_i);
    mt   = lin_map(A2T, mask_i);
    qq   = q_i ^ {{(NIB_W-SUB_W){1'b0}}, r_i};
    am10 = mul16(at[7:4], mt[3:0]);
    am01 = mul16(mt[7:4], at[3:0]);
    m01  = mul16(mt[7:4], mt[3:0]);
    // serial chains, auxiliary mask first
    h1 = qq;
    h1 = h1 ^ mul16(sq16(at[7:4]), NU);
    h1 = h1 ^ sq16(at[3:0]);
    h1 = h1 ^ mul16(at[7:4], at[3:0]);
    h1 = h1 ^ am10;
    h1 = h1 ^ am01;
    h2 = qq;
    h2 = h2 ^ mul16(sq16(mt[7:4]), NU);
    h2 = h2 ^ sq16(mt[3:0]);
    h2 = h2 ^ m01;
  end

  assign h1_o   = eval_i ? h1 : '0;
  assign h2_o   = eval_i ? h2 : '0;
  assign ahm_o  = eval_i ? at[7:4] : '0;
  assign alm_o  = eval_i ? at[3:0] : '0;
  assign am10_o = eval_i ? am10 : '0;
  assign am01_o = eval_i ? am01 : '0;
  assign m01_o  = eval_i ? m01 : '0;
  assign mt_o   = eval_i ? mt : '0;

  a_r6_precharge_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |-> (h1_o == '0 && h2_o == '0 && mt_o == '0));
endmodule

// File: rtl/sbox_inv_hide.sv
module sbox_inv_hide
  import sbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [NIB_W-1:0]  value_i,
  output logic [CODE_W-1:0] code_o
);
  logic [NIB_W-1:0] inv, word;
  logic             flag;
  logic [1:0]       fill;
  int               hw;

  always_comb begin
    inv  = inv16(value_i);
    hw   = $countones(inv);
    flag = hw > 2;
    word = flag ? ~inv : inv;
    unique case ($countones({flag, word}))
      0:       fill = 2'b11;
      1:       fill = 2'b01;
      default: fill = 2'b00;
    endcase
  end

  assign code_o = eval_i ? {fill, flag, word} : '0;

  a_r1_code_weight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |-> $countones(code_o) == 2);
  a_r1_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && value_i != '0) |->
      mul16(code_o[3:0] ^ {NIB_W{code_o[4]}}, value_i) == 4'h1);
  a_r6_inv_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |-> code_o == '0);
endmodule

// File: rtl/sbox_stage3.sv
module sbox_stage3
  import sbox_pkg::*;
(
  input  logic              eval_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [NIB_W-1:0]  ahm_i,
  input  logic [NIB_W-1:0]  alm_i,
  input  logic [NIB_W-1:0]  am10_i,
  input  logic [NIB_W-1:0]  am01_i,
  input  logic [NIB_W-1:0]  m01_i,
  input  logic [BYTE_W-1:0] mt_i,
  input  logic [BYTE_W-1:0] mf_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] mask_o
);
  logic [NIB_W-1:0]  d, d0, d1, bh, bl;
  logic [BYTE_W-1:0] dat, msk;

  always_comb begin
    d  = code_i[3:0] ^ {NIB_W{code_i[4]}};
    d0 = mt_i[3:0] ^ d;   // remask, both halves in parallel
    d1 = mt_i[7:4] ^ d;
    bh = mf_i[7:4];
    bh = bh ^ mul16(ahm_i, d0);
    bh = bh ^ mul16(mt_i[7:4], d0);
    bh = bh ^ am10_i;
    bh = bh ^ m01_i;
    bl = mf_i[3:0];
    bl = bl ^ bh;
    bl = bl ^ mf_i[7:4];
    bl = bl ^ mul16(alm_i, d1);
    bl = bl ^ mul16(mt_i[3:0], d1);
    bl = bl ^ am01_i;
    bl = bl ^ m01_i;
    dat = affine_lin(lin_map(T2A, {bh, bl})) ^ AFF_C;
    msk = affine_lin(lin_map(T2A, mf_i));
  end

  assign data_o = eval_i ? dat : '0;
  assign mask_o = eval_i ? msk : '0;
endmodule

// File: rtl/masked_sbox_top.sv
module masked_sbox_top
  import sbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              ready_o,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [BYTE_W-1:0] mask_i,
  input  logic [NIB_W-1:0]  q_i,
  input  logic [SUB_W-1:0]  r_i,
  input  logic [BYTE_W-1:0] rnd_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] mask_o
);
  logic phase_q, accept, v1_q, v2_q;
  logic [NIB_W-1:0]  s1_h1, s1_h2, s1_ahm, s1_alm, s1_am10, s1_am01, s1_m01;
  logic [BYTE_W-1:0] s1_mt;
  logic [NIB_W-1:0]  r1_h1, r1_h2;
  logic [BYTE_W-1:0] r1_mt, r1_mf, r2_mt, r2_mf;
  logic [NIB_W-1:0]  rc_ahm, rc_alm, rc_am10, rc_am01, rc_m01;
  logic [CODE_W-1:0] s2_code, r2_code;

  assign ready_o = phase_q;
  assign accept  = in_valid_i & phase_q;
  assign valid_o = v2_q & phase_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;

  sbox_stage1 u_s1 (
    .clk_i, .rst_ni, .eval_i(phase_q), .data_i, .mask_i, .q_i, .r_i,
    .h1_o(s1_h1), .h2_o(s1_h2), .ahm_o(s1_ahm), .alm_o(s1_alm),
    .am10_o(s1_am10), .am01_o(s1_am01), .m01_o(s1_m01), .mt_o(s1_mt)
  );

  // R1 and the shared-term group, loaded once per operation
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      v1_q <= 1'b0;
      r1_h1 <= '0; r1_h2 <= '0; r1_mt <= '0; r1_mf <= '0;
      rc_ahm <= '0; rc_alm <= '0; rc_am10 <= '0; rc_am01 <= '0; rc_m01 <= '0;
    end else if (phase_q) begin
      v1_q <= accept;
      if (accept) begin
        r1_h1 <= s1_h1; r1_h2 <= s1_h2; r1_mt <= s1_mt; r1_mf <= rnd_i;
        rc_ahm <= s1_ahm; rc_alm <= s1_alm;
        rc_am10 <= s1_am10; rc_am01 <= s1_am01; rc_m01 <= s1_m01;
      end
    end

  sbox_inv_hide u_inv (
    .clk_i, .rst_ni, .eval_i(~phase_q), .value_i(r1_h1 ^ r1_h2), .code_o(s2_code)
  );

  // R2
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      v2_q <= 1'b0; r2_code <= '0; r2_mt <= '0; r2_mf <= '0;
    end else if (!phase_q) begin
      v2_q <= v1_q;
      if (v1_q) begin
        r2_code <= s2_code; r2_mt <= r1_mt; r2_mf <= r1_mf;
      end
    end

  sbox_stage3 u_s3 (
    .eval_i(valid_o), .code_i(r2_code), .ahm_i(rc_ahm), .alm_i(rc_alm),
    .am10_i(rc_am10), .am01_i(rc_am01), .m01_i(rc_m01),
    .mt_i(r2_mt), .mf_i(r2_mf), .data_o, .mask_o
  );

  a_r3_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r3_ready_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(in_valid_i && ready_o, 2));
  a_r4_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0 && mask_o == '0));
endmodule

// File: tb/masked_sbox_top_test.sv
`timescale 1ns/1ps
module masked_sbox_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] data, mask, rnd;
  logic [3:0] q;
  logic [1:0] r;
  logic       ready, valid;
  logic [7:0] dout, mout;

  int errors = 0;
  int checks = 0;
  logic [7:0] sref [256];

  always #4 clk = ~clk;

  masked_sbox_top uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .ready_o(ready),
    .data_i(data), .mask_i(mask), .q_i(q), .r_i(r), .rnd_i(rnd),
    .valid_o(valid), .data_o(dout), .mask_o(mout)
  );

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] d, input logic [7:0] m, input logic [3:0] qa,
                        input logic [1:0] ra, input logic [7:0] rn,
                        output logic [7:0] od, output logic [7:0] om);
    while (ready !== 1'b1) @(negedge clk);
    in_valid = 1'b1; data = d; mask = m; q = qa; r = ra; rnd = rn;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 no result one cycle after acceptance", valid, 1'b0);
    @(negedge clk);
    chk("R4 result two edges after acceptance", valid, 1'b1);
    od = dout;
    om = mout;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] od, om, od2, om2, oa, ob, oab;
    logic [31:0] seed;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, b;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      b = inv;
      for (int n = 1; n <= 4; n++) b ^= (inv << n) | (inv >> (8 - n));
      sref[x] = b ^ 8'h63;
    end

    rst_n = 1'b0; in_valid = 1'b0; data = '0; mask = '0; q = '0; r = '0; rnd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 valid low in reset", valid, 1'b0);
    chk("R10 outputs zero in reset", {dout, mout}, 16'h0);
    rst_n = 1'b1;
    chk("R10 valid low after reset", valid, 1'b0);
    chk("R10 outputs zero after reset", {dout, mout}, 16'h0);
    chk("R3 ready low first cycle", ready, 1'b0);
    @(negedge clk);
    chk("R3 ready high second cycle", ready, 1'b1);
    @(negedge clk);
    chk("R3 ready low third cycle", ready, 1'b0);

    // R5: offer while not ready
    in_valid = 1'b1; data = 8'h53; mask = 8'h0F; rnd = 8'h77;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R5 ignored offer gives no valid", valid, 1'b0);
      chk("R6 outputs zero while idle", {dout, mout}, 16'h0);
      @(negedge clk);
    end

    // R9 zero element
    run_op(8'hA7, 8'hA7, 4'h9, 2'h1, 8'h3C, od, om);
    chk("R9 zero input maps to 63", od ^ om, 8'h63);
    @(negedge clk);
    chk("R4 valid lasts one cycle", valid, 1'b0);
    chk("R6 outputs zero after result", {dout, mout}, 16'h0);

    // R7 auxiliary masks have no effect
    run_op(8'h5A, 8'hC3, 4'h0, 2'h0, 8'h81, od, om);
    run_op(8'h5A, 8'hC3, 4'hF, 2'h3, 8'h81, od2, om2);
    chk("R7 data_o independent of q and r", od2, od);
    chk("R7 mask_o independent of q and r", om2, om);
    run_op(8'h5A, 8'hC3, 4'h6, 2'h2, 8'h81, od2, om2);
    chk("R7 data_o independent of q and r", od2, od);
    chk("R1 result for 99", od ^ om, sref[8'h99]);

    // R2 output mask behaviour
    run_op(8'h3C, 8'hA5, 4'h2, 2'h1, 8'h00, od, om);
    chk("R2 zero rnd gives zero mask", om, 8'h00);
    chk("R1 unmasked output with zero rnd", od, sref[8'h3C ^ 8'hA5]);
    run_op(8'h3C, 8'hA5, 4'h2, 2'h1, 8'h1F, od, oa);
    run_op(8'h3C, 8'hA5, 4'h2, 2'h1, 8'hC2, od, ob);
    run_op(8'h3C, 8'hA5, 4'h2, 2'h1, 8'hDD, od, oab);
    chk("R2 mask linear in rnd", oa ^ ob, oab);
    run_op(8'hE1, 8'h04, 4'h2, 2'h1, 8'h1F, od, om);
    chk("R2 mask independent of data", om, oa);

    // R1 and R8: back-to-back sweep of all bytes under four mask patterns
    seed = 32'h1234_5678;
    for (int k = 0; k < 4; k++)
      for (int x = 0; x < 256; x++) begin
        logic [7:0] m;
        seed = seed * 32'd1664525 + 32'd1013904223;
        m = (k == 0) ? 8'h00 : seed[31:24];
        run_op(8'(x) ^ m, m, seed[11:8], seed[13:12], (k == 0) ? 8'h00 : seed[23:16], od, om);
        chk("R1 R8 unmasked result matches S-box", od ^ om, sref[x]);
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule